// File: doc/BRIEF.md
# Two-Dimensional Systolic Hadamard Array

This block computes a four-point Hadamard transform on a stream of signed sample vectors. A grid of registered add/subtract cells does the work: four rows, one for each output coefficient, and three arithmetic columns. The kernel has only +1 and -1 entries, so no cell multiplies.

Samples move down the columns through a vertical register pipeline. Partial sums move along the rows through a horizontal register pipeline. The input vector is skewed so that each sample meets its row partial in the right cycle. Row k has its coefficient ready k + 3 cycles after the vector is accepted. The first row is therefore ready three cycles after the vector enters. The grid is full seven cycles after the vector enters.

The four row results are then deskewed and registered together. A complete, aligned coefficient vector leaves with a single valid pulse. Once the pipeline is full, the block takes a new vector and delivers a finished vector on every clock.

Both edges carry valid strobes only. There is no ready signal and no back-pressure. The consumer must accept each result in the cycle it appears. Cycles without `in_valid` pass through the pipeline as bubbles, and those cycles give no result.

Top module: `hadamard_systolic_array`

## Requirements
- R1: Sample j sits at bits [8j+7:8j] of `in_samples`, and coefficient k sits at bits [10k+9:10k] of `out_coefs`. Coefficient k is the sum over j = 0..3 of s_j·x_j, where s_j = -1 when (k AND j) has an odd number of set bits and s_j = +1 otherwise. For example, coefficient 1 is x0 - x1 + x2 - x3.
- R2: A vector captured on a clock edge with `in_valid` high appears on `out_coefs`, with `out_valid` high, right after the seventh following edge.
- R3: `out_valid` is `in_valid` delayed by seven edges. Every gap in the input stream shows up as a gap of the same length and position at the output, and an idle cycle never yields a result.
- R4: Vectors presented on consecutive cycles leave on consecutive cycles. Each result is correct, and throughput is one vector per clock.
- R5: Inputs are 8-bit two's complement and outputs are 10-bit two's complement. Every combination of inputs gives an exact result, including the extremes: all -128 gives -512 on coefficient 0, and (127, -128, -128, 127) gives 510 on coefficient 3.
- R6: A synchronous active-high `rst` clears every pipeline register and valid flag. After a reset edge, `out_valid` is 0 and `out_coefs` is 0. Vectors in flight at reset never emerge, so `out_valid` stays 0 for seven edges after reset unless new vectors are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_samples` as a vector to transform |
| in_samples | input | 32 | Four signed 8-bit samples, sample j in bits [8j+7:8j] |
| out_valid | output | 1 | Marks `out_coefs` as a finished transform |
| out_coefs | output | 40 | Four signed 10-bit coefficients, coefficient k in bits [10k+9:10k] |

## Verification
Each finished vector and its valid pulse are due exactly seven edges after the edge that captured the input. The reference model therefore logs the valid bit and samples captured on each edge. Half a cycle after each edge, it compares the outputs with the log entry from seven edges earlier, using a direct ±1 sum.

A reset edge clears the log entries for the seven edges up to and including that reset edge. After that, any leftover result the design still lets through counts as a mismatch. Isolated vectors, back-to-back bursts and randomly gapped streams are all checked against the same log, so latency, bubble placement and throughput are measured in the same way.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

  // Default transform size and sample width for the array.
  localparam int unsigned HSA_POINTS   = 4;
  localparam int unsigned HSA_SAMPLE_W = 8;

  // Sign of kernel entry (row, col): negative when the shared bits are odd in number.
  function automatic bit row_col_negates(input int unsigned row, input int unsigned col);
    logic [31:0] shared;
    shared = row & col;
    return ^shared;
  endfunction

endpackage

// File: rtl/hsa_skew.sv
module hsa_skew #(
  parameter int PTS  = 4,
  parameter int IN_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PTS*IN_W-1:0]   vec_in,
  output logic [PTS*IN_W-1:0]   vec_skewed
);

  // Columns 0 and 1 enter the grid together; column j >= 2 lags by j-1 cycles.
  for (genvar j = 0; j < PTS; j++) begin : g_col
    if (j < 2) begin : g_pass
      assign vec_skewed[j*IN_W +: IN_W] = vec_in[j*IN_W +: IN_W];
    end else begin : g_delay
      localparam int DEPTH = j - 1;
      logic [IN_W-1:0] stage [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int m = 0; m < DEPTH; m++) stage[m] <= '0;
        end else begin
          stage[0] <= vec_in[j*IN_W +: IN_W];
          for (int m = 1; m < DEPTH; m++) stage[m] <= stage[m-1];
        end
      end
      assign vec_skewed[j*IN_W +: IN_W] = stage[DEPTH-1];
    end
  end

endmodule

// File: rtl/hsa_cell.sv
module hsa_cell #(
  parameter int ACC_W    = 10,
  parameter int SMP_W    = 8,
  parameter bit SUBTRACT = 1'b0,
  parameter int TERMS    = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] acc_in,
  input  logic signed [SMP_W-1:0] smp_in,
  output logic signed [ACC_W-1:0] acc_out
);

  localparam int BOUND = TERMS * (2 ** (SMP_W - 1));

  logic signed [ACC_W-1:0] smp_ext;
  logic signed [ACC_W-1:0] result;

  assign smp_ext = {{(ACC_W-SMP_W){smp_in[SMP_W-1]}}, smp_in};

  if (SUBTRACT) begin : g_sub
    assign result = acc_in - smp_ext;
  end else begin : g_add
    assign result = acc_in + smp_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_out <= '0;
    else     acc_out <= result;
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(acc_out) <= BOUND) && (int'(acc_out) >= -BOUND));

endmodule

// File: rtl/hsa_grid.sv
module hsa_grid #(
  parameter int PTS   = 4,
  parameter int IN_W  = 8,
  parameter int OUT_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PTS*IN_W-1:0]   col_in,
  output logic [PTS*OUT_W-1:0]  row_sum
);

  // Vertical pipeline: one register per row per column.
  logic signed [IN_W-1:0]  vert [PTS][PTS];
  // Horizontal pipeline: partial sums along each row.
  logic signed [OUT_W-1:0] part [PTS][PTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < PTS; k++)
        for (int j = 0; j < PTS; j++)
          vert[k][j] <= '0;
    end else begin
      for (int j = 0; j < PTS; j++) vert[0][j] <= col_in[j*IN_W +: IN_W];
      for (int k = 1; k < PTS; k++)
        for (int j = 0; j < PTS; j++)
          vert[k][j] <= vert[k-1][j];
    end
  end

  for (genvar k = 0; k < PTS; k++) begin : g_row
    // Column 0 always carries +1, so it seeds the row without a cell.
    assign part[k][0] = {{(OUT_W-IN_W){vert[k][0][IN_W-1]}}, vert[k][0]};
    for (genvar j = 1; j < PTS; j++) begin : g_cell
      hsa_cell #(
        .ACC_W   (OUT_W),
        .SMP_W   (IN_W),
        .SUBTRACT(hsa_pkg::row_col_negates(k, j)),
        .TERMS   (j + 1)
      ) i_cell (
        .clk    (clk),
        .rst    (rst),
        .acc_in (part[k][j-1]),
        .smp_in (vert[k][j]),
        .acc_out(part[k][j])
      );
    end
    assign row_sum[k*OUT_W +: OUT_W] = part[k][PTS-1];
  end

endmodule

// File: rtl/hsa_deskew.sv
module hsa_deskew #(
  parameter int PTS   = 4,
  parameter int OUT_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PTS*OUT_W-1:0]  rows_in,
  output logic [PTS*OUT_W-1:0]  rows_aligned
);

  // Row k finishes k cycles after row 0; delay it by PTS-1-k to align.
  for (genvar k = 0; k < PTS; k++) begin : g_row
    localparam int DEPTH = PTS - 1 - k;
    if (DEPTH == 0) begin : g_pass
      assign rows_aligned[k*OUT_W +: OUT_W] = rows_in[k*OUT_W +: OUT_W];
    end else begin : g_delay
      logic [OUT_W-1:0] stage [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int m = 0; m < DEPTH; m++) stage[m] <= '0;
        end else begin
          stage[0] <= rows_in[k*OUT_W +: OUT_W];
          for (int m = 1; m < DEPTH; m++) stage[m] <= stage[m-1];
        end
      end
      assign rows_aligned[k*OUT_W +: OUT_W] = stage[DEPTH-1];
    end
  end

endmodule

// File: rtl/hadamard_systolic_array.sv
module hadamard_systolic_array #(
  parameter  int PTS   = hsa_pkg::HSA_POINTS,
  parameter  int IN_W  = hsa_pkg::HSA_SAMPLE_W,
  localparam int OUT_W = IN_W + $clog2(PTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [PTS*IN_W-1:0]   in_samples,
  output logic                  out_valid,
  output logic [PTS*OUT_W-1:0]  out_coefs
);

  localparam int LAT   = 2 * PTS - 1;
  localparam int LOG_P = $clog2(PTS);
  localparam int CNT_W = $clog2(LAT + 2) + 1;
  localparam int SUM_W = OUT_W + LOG_P + 1;

  logic [PTS*IN_W-1:0]  skewed;
  logic [PTS*OUT_W-1:0] row_sums;
  logic [PTS*OUT_W-1:0] aligned;
  logic [LAT:0]         vld_pipe;

  hsa_skew #(.PTS(PTS), .IN_W(IN_W)) i_skew (
    .clk(clk), .rst(rst), .vec_in(in_samples), .vec_skewed(skewed)
  );

  hsa_grid #(.PTS(PTS), .IN_W(IN_W), .OUT_W(OUT_W)) i_grid (
    .clk(clk), .rst(rst), .col_in(skewed), .row_sum(row_sums)
  );

  hsa_deskew #(.PTS(PTS), .OUT_W(OUT_W)) i_deskew (
    .clk(clk), .rst(rst), .rows_in(row_sums), .rows_aligned(aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_pipe  <= '0;
      out_coefs <= '0;
    end else begin
      vld_pipe  <= {vld_pipe[LAT-1:0], in_valid};
      out_coefs <= aligned;
    end
  end

  assign out_valid = vld_pipe[LAT];

  // Checker state: cycles since reset and vectors in flight.
  logic [CNT_W-1:0]        fill_cnt;
  logic [CNT_W-1:0]        inflight;
  logic signed [SUM_W-1:0] coef_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_cnt <= '0;
      inflight <= '0;
    end else begin
      if (fill_cnt < CNT_W'(LAT)) fill_cnt <= fill_cnt + 1'b1;
      inflight <= inflight + CNT_W'(in_valid) - CNT_W'(out_valid);
    end
  end

  always_comb begin
    coef_sum = '0;
    for (int k = 0; k < PTS; k++)
      coef_sum = coef_sum + SUM_W'($signed(out_coefs[k*OUT_W +: OUT_W]));
  end

  // R6
  fill_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt < CNT_W'(LAT)) |-> !out_valid);

  // R3
  inflight_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid |-> (inflight != '0)) && (inflight <= CNT_W'(LAT + 1)));

  // R1: the coefficients of one vector sum to PTS times sample 0
  sum_mult_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (coef_sum[LOG_P-1:0] == '0));

endmodule

// File: tb/test_hadamard_systolic_array.sv
`timescale 1ns/1ps
module test_hadamard_systolic_array;

  localparam int PTS   = 4;
  localparam int IN_W  = 8;
  localparam int OUT_W = 10;
  localparam int LAT   = 7;
  localparam int MAXC  = 4096;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic [PTS*IN_W-1:0]  in_samples = '0;
  logic                 out_valid;
  logic [PTS*OUT_W-1:0] out_coefs;

  always #2.5 clk = ~clk;

  hadamard_systolic_array i_hadamard_systolic_array (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_samples(in_samples),
    .out_valid(out_valid), .out_coefs(out_coefs)
  );

  int checks = 0;
  int errors = 0;
  int edge_n = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  bit rec_v [MAXC];
  int rec_x [MAXC][PTS];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_coef(input int idx, input int k);
    int acc = 0;
    for (int j = 0; j < PTS; j++) begin
      if ($countones(k & j) % 2 == 1) acc -= rec_x[idx][j];
      else                            acc += rec_x[idx][j];
    end
    return acc;
  endfunction

  task automatic compare(input string dtag);
    int idx;
    bit expv;
    idx  = edge_n - LAT;
    expv = (idx >= 1) ? rec_v[idx] : 1'b0;
    if (!checking) return;
    if (expv) chk(out_valid == 1'b1, "R2", "out_valid", int'(out_valid), 1);
    else      chk(out_valid == 1'b0, "R3", "out_valid", int'(out_valid), 0);
    if (expv) begin
      for (int k = 0; k < PTS; k++) begin
        int act;
        act = int'($signed(out_coefs[k*OUT_W +: OUT_W]));
        chk(act == ref_coef(idx, k), dtag, $sformatf("coef %0d", k), act, ref_coef(idx, k));
      end
    end
  endtask

  task automatic cyc(input bit r, input bit v, input int a0, input int a1,
                     input int a2, input int a3, input string dtag);
    rst        = r;
    in_valid   = v;
    in_samples = {8'(a3), 8'(a2), 8'(a1), 8'(a0)};
    edge_n++;
    rec_v[edge_n]    = v && !r;
    rec_x[edge_n][0] = a0;
    rec_x[edge_n][1] = a1;
    rec_x[edge_n][2] = a2;
    rec_x[edge_n][3] = a3;
    if (r) begin
      for (int i = edge_n - LAT + 1; i <= edge_n; i++)
        if (i >= 1) rec_v[i] = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    compare(dtag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 0, 0, 0, 0, "R3");
  endtask

  function automatic int rnd_smp();
    return int'($urandom_range(255)) - 128;
  endfunction

  task automatic check_cleared();
    chk(out_valid == 1'b0, "R6", "out_valid after reset", int'(out_valid), 0);
    for (int k = 0; k < PTS; k++) begin
      int act;
      act = int'($signed(out_coefs[k*OUT_W +: OUT_W]));
      chk(act == 0, "R6", $sformatf("coef %0d after reset", k), act, 0);
    end
  endtask

  initial begin
    cyc(1'b1, 1'b0, 0, 0, 0, 0, "R6");
    checking = 1'b1;
    cyc(1'b1, 1'b0, 0, 0, 0, 0, "R6");
    cyc(1'b1, 1'b0, 0, 0, 0, 0, "R6");
    check_cleared();

    // R1: impulses and simple patterns, isolated vectors (R2 latency)
    cyc(1'b0, 1'b1, 1, 0, 0, 0, "R1"); idle(9);
    cyc(1'b0, 1'b1, 0, 1, 0, 0, "R1"); idle(9);
    cyc(1'b0, 1'b1, 0, 0, 1, 0, "R1"); idle(9);
    cyc(1'b0, 1'b1, 0, 0, 0, 1, "R1"); idle(9);
    cyc(1'b0, 1'b1, 3, -5, 7, -11, "R1"); idle(3);
    cyc(1'b0, 1'b1, 10, 20, 30, 40, "R1"); idle(9);

    // R5: extreme operands
    cyc(1'b0, 1'b1, 127, 127, 127, 127, "R5");
    cyc(1'b0, 1'b1, -128, -128, -128, -128, "R5");
    cyc(1'b0, 1'b1, 127, -128, -128, 127, "R5");
    cyc(1'b0, 1'b1, -128, 127, 127, -128, "R5");
    cyc(1'b0, 1'b1, 127, -128, 127, -128, "R5");
    cyc(1'b0, 1'b1, -128, -128, 127, 127, "R5");
    idle(10);

    // R4: back-to-back burst
    for (int i = 0; i < 60; i++)
      cyc(1'b0, 1'b1, rnd_smp(), rnd_smp(), rnd_smp(), rnd_smp(), "R4");
    idle(10);

    // R3: random gaps
    for (int i = 0; i < 600; i++)
      cyc(1'b0, ($urandom_range(99) < 45), rnd_smp(), rnd_smp(), rnd_smp(), rnd_smp(), "R3");
    idle(10);

    // R6: reset with vectors in flight
    for (int i = 0; i < 5; i++)
      cyc(1'b0, 1'b1, rnd_smp(), rnd_smp(), rnd_smp(), rnd_smp(), "R6");
    cyc(1'b1, 1'b1, 50, 60, 70, 80, "R6");
    check_cleared();
    cyc(1'b1, 1'b0, 0, 0, 0, 0, "R6");
    idle(10);

    // Mixed stream after reset
    for (int i = 0; i < 300; i++)
      cyc(1'b0, ($urandom_range(99) < 70), rnd_smp(), rnd_smp(), rnd_smp(), rnd_smp(), "R1");
    idle(12);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule